// File: doc/BRIEF.md
# Supply Undervoltage / Overvoltage Supervisor with Power-Good

This block is the digital stage behind a set of supply comparators in a hot-swap controller. It takes the raw comparator outputs for the supply level, the drain level and the gate level. Each one passes through a multi-flop synchroniser. The block then keeps an undervoltage fault state and an overvoltage fault state, requests a gate shutdown while either fault is present, and drives an active-low power-good signal.

Undervoltage has a hysteresis band built from two comparators. The fault sets when the lower comparator reports the supply below its threshold. It clears only once the upper comparator reports the supply above its own, higher threshold. Overvoltage follows its comparator directly. While the overvoltage fault is active, the block enables the hysteresis current source that the analog front end uses to lower the trip point. Power-good is pulled low only when the drain is low, the gate is near its rail, hot swap is on and no fault is active.

Top module: `supply_supervisor`

## Requirements
- R1: After reset, `uv_flag_o` is 1, `ov_flag_o` is 0, `ov_hyst_en_o` is 0, `gate_off_o` is 1 and `pgood_n_o` is 1.
- R2: When `uvl_ok_i` is 0 (supply below the low threshold), `uv_flag_o` becomes 1 no later than the third rising clock edge after the input change.
- R3: `uv_flag_o` goes from 1 to 0 only after `uvh_ok_i` is seen at 1 (supply above the high threshold). `uvl_ok_i` returning to 1 on its own leaves the flag set. With `uvl_ok_i`=1 and `uvh_ok_i`=0, the flag holds its value.
- R4: If `uvl_ok_i`=0 and `uvh_ok_i`=1 at the same time, the set wins and `uv_flag_o` is 1.
- R5: `ov_flag_o` follows `ov_high_i` with a latency of exactly three rising clock edges, both on assertion and on release.
- R6: `ov_hyst_en_o` is 1 exactly while `ov_flag_o` is 1. It drops when the overvoltage comparator deasserts.
- R7: `gate_off_o` is 1 whenever `uv_flag_o` or `ov_flag_o` is 1, and 0 otherwise.
- R8: `pgood_n_o` is 0 only when the synchronised `drain_low_i`=1, `gate_high_i`=1 and `hs_on_i`=1, and no fault is active.
- R9: `pgood_n_o` is 1 whenever hot swap is off or either fault flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvl_ok_i | input | 1 | Low UV comparator, 1 = supply above low threshold |
| uvh_ok_i | input | 1 | High UV comparator, 1 = supply above high threshold |
| ov_high_i | input | 1 | OV comparator, 1 = supply above OV threshold |
| drain_low_i | input | 1 | Drain comparator, 1 = drain below its threshold |
| gate_high_i | input | 1 | 1 = gate near its upper rail |
| hs_on_i | input | 1 | Hot swap enabled by the main controller |
| gate_off_o | output | 1 | Gate shutdown request |
| uv_flag_o | output | 1 | Undervoltage fault status |
| ov_flag_o | output | 1 | Overvoltage fault status |
| ov_hyst_en_o | output | 1 | OV hysteresis current enable |
| pgood_n_o | output | 1 | Power good, active low |

## Verification
A wrong undervoltage state appears at the ports in three ways. `gate_off_o` is stuck high, `pgood_n_o` stays high although drain and gate conditions hold, or the flag clears while the supply is still inside the hysteresis band. Each of these is visible three edges after the comparator change. A wrong overvoltage state shows as a mismatch between `ov_flag_o` and `ov_hyst_en_o`, or as a power-good that stays low during a fault. The edge-exact latency check catches a missing or extra synchroniser stage within one cycle.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // Undervoltage state update: a set from the low comparator beats a clear from the high one
  function automatic logic uv_next(input logic cur, input logic lo_ok, input logic hi_ok);
    if (!lo_ok)      return 1'b1;
    else if (hi_ok)  return 1'b0;
    else             return cur;
  endfunction

  // Power-good condition, active high
  function automatic logic pg_ok(input logic drain_lo, input logic gate_hi, input logic on,
                                 input logic uv, input logic ov);
    return drain_lo & gate_hi & on & ~uv & ~ov;
  endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/supv_fault.sv
module supv_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_ok_s,
  input  logic hi_ok_s,
  input  logic ov_s,
  output logic uv_q,
  output logic ov_q,
  output logic hyst_q
);
  import supv_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_q   <= 1'b1;
      ov_q   <= 1'b0;
      hyst_q <= 1'b0;
    end else begin
      uv_q   <= uv_next(uv_q, lo_ok_s, hi_ok_s);
      ov_q   <= ov_s;
      hyst_q <= ov_s;
    end
  end

  assert_uv_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_ok_s |=> uv_q);
  assert_uv_clear_needs_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_q && !hi_ok_s) |=> uv_q);
  assert_uv_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_ok_s && hi_ok_s) |=> uv_q);
  assert_ov_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ov_s |=> ov_q);
  assert_ov_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ov_s |=> !ov_q);
  assert_hyst_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hyst_q == ov_q);
endmodule

// File: rtl/supv_pgood.sv
module supv_pgood (
  input  logic drain_s,
  input  logic gate_s,
  input  logic on_s,
  input  logic uv,
  input  logic ov,
  output logic gate_off,
  output logic pgood_n
);
  import supv_pkg::*;

  always_comb begin
    gate_off = uv | ov;
    pgood_n  = ~pg_ok(drain_s, gate_s, on_s, uv, ov);
  end
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uvl_ok_i,
  input  logic uvh_ok_i,
  input  logic ov_high_i,
  input  logic drain_low_i,
  input  logic gate_high_i,
  input  logic hs_on_i,
  output logic gate_off_o,
  output logic uv_flag_o,
  output logic ov_flag_o,
  output logic ov_hyst_en_o,
  output logic pgood_n_o
);
  localparam int NIN = 6;

  logic [NIN-1:0] raw_in, syn_in;
  logic lo_ok_s, hi_ok_s, ov_s, drain_s, gate_s, on_s;
  logic uv_state, ov_state, hyst_state;

  assign raw_in = {hs_on_i, gate_high_i, drain_low_i, ov_high_i, uvh_ok_i, uvl_ok_i};

  supv_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_in));

  assign {on_s, gate_s, drain_s, ov_s, hi_ok_s, lo_ok_s} = syn_in;

  supv_fault fault_i (
    .clk(clk), .rst_n(rst_n), .lo_ok_s(lo_ok_s), .hi_ok_s(hi_ok_s), .ov_s(ov_s),
    .uv_q(uv_state), .ov_q(ov_state), .hyst_q(hyst_state));

  supv_pgood pgood_i (
    .drain_s(drain_s), .gate_s(gate_s), .on_s(on_s), .uv(uv_state), .ov(ov_state),
    .gate_off(gate_off_o), .pgood_n(pgood_n_o));

  assign uv_flag_o    = uv_state;
  assign ov_flag_o    = ov_state;
  assign ov_hyst_en_o = hyst_state;

  assert_gate_off_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_flag_o || ov_flag_o) |-> gate_off_o);
  assert_pgood_needs_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pgood_n_o |-> (drain_s && gate_s && on_s));
  assert_pgood_off_on_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_s || uv_state || ov_state) |-> pgood_n_o);
endmodule

// File: tb/supply_supervisor_tb_top.sv
module supply_supervisor_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvl_ok, uvh_ok, ov_hi, drain_lo, gate_hi, hs_on;
  logic gate_off, uv_flag, ov_flag, hyst_en, pgood_n;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .uvl_ok_i(uvl_ok), .uvh_ok_i(uvh_ok), .ov_high_i(ov_hi),
    .drain_low_i(drain_lo), .gate_high_i(gate_hi), .hs_on_i(hs_on),
    .gate_off_o(gate_off), .uv_flag_o(uv_flag), .ov_flag_o(ov_flag),
    .ov_hyst_en_o(hyst_en), .pgood_n_o(pgood_n));

  // {lo_ok, hi_ok, ov, drain, gate, on, exp_uv, exp_ov, exp_pgood_n}
  localparam int NV = 13;
  localparam logic [8:0] VEC [NV] = '{
    9'b100111_101, // R3 low ok only: UV held set
    9'b110111_000, // R8 UV cleared, power good
    9'b100111_000, // R3 inside band: clear held
    9'b000111_101, // R2 low drops: UV set
    9'b100111_101, // R3 low back alone: still set
    9'b110111_000, // R3 high seen: cleared
    9'b111111_011, // R5 R9 OV trip
    9'b110111_000, // R5 R6 OV release
    9'b110110_001, // R9 hot swap off
    9'b110011_001, // R8 drain not low
    9'b110101_001, // R8 gate not high
    9'b110111_000, // R8 all conditions
    9'b010111_101  // R4 set beats clear
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] v);
    {uvl_ok, uvh_ok, ov_hi, drain_lo, gate_hi, hs_on} = v;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    drive(6'b000000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 uv", uv_flag, 1'b1);
    chk("R1 ov", ov_flag, 1'b0);
    chk("R1 hyst", hyst_en, 1'b0);
    chk("R1 gate_off", gate_off, 1'b1);
    chk("R1 pgood_n", pgood_n, 1'b1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][8:3]);
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2/R3/R4 uv vec%0d", i), uv_flag, VEC[i][2]);
      chk($sformatf("R5 ov vec%0d", i), ov_flag, VEC[i][1]);
      chk($sformatf("R8/R9 pgood_n vec%0d", i), pgood_n, VEC[i][0]);
      chk($sformatf("R6 hyst vec%0d", i), hyst_en, VEC[i][1]);
      chk($sformatf("R7 gate_off vec%0d", i), gate_off, VEC[i][2] | VEC[i][1]);
    end

    // R5 exact latency: clear supply, then raise OV
    @(negedge clk);
    drive(6'b110111);
    repeat (4) @(posedge clk);
    @(negedge clk);
    ov_hi = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R5 ov not before third edge", ov_flag, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R5 ov at third edge", ov_flag, 1'b1);
    chk("R6 hyst with ov", hyst_en, 1'b1);
    ov_hi = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R5 ov held before third edge", ov_flag, 1'b1);
    @(posedge clk);
    @(negedge clk);
    chk("R5 ov released at third edge", ov_flag, 1'b0);
    chk("R6 hyst dropped", hyst_en, 1'b0);

    // R2 latency of undervoltage set
    uvl_ok = 1'b0;
    uvh_ok = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 uv by third edge", uv_flag, 1'b1);
    chk("R9 pgood_n during uv", pgood_n, 1'b1);

    // R1 reset mid-run restores state
    drive(6'b110111);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 uv after reset", uv_flag, 1'b1);
    chk("R1 pgood_n after reset", pgood_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule